// File: doc/BRIEF.md
# Cartridge Work-RAM Enable Decoder

This block drives the chip enable and write enable of a cartridge work RAM on a console whose cartridge slot never receives CPU address line A15. It sees only A14, A13, the read/write line, the CPU phase clock M2 and an active-low ROM select. That ROM select follows the inverse of M2 whenever A15 is high and stays high otherwise. The block decodes the $6000-$7FFF window from these signals. It infers the missing A15 from how ROM select behaves relative to M2.

All CPU-side inputs are brought into a fast oversampling clock through a synchroniser. The fast clock runs at eight or more times the M2 rate. During a $E000-$FFFF access, ROM select falls a short time after M2 rises, and in that interval the decode briefly matches the RAM window. To hide this, the RAM enable is qualified by a copy of M2 that is delayed by a few fast cycles. The block also produces a single-cycle strobe for writes to mapper registers. It drops the second of the two back-to-back writes that a read-modify-write instruction makes.

Top module: `wram_decode`

## Requirements
- R1: While `rst` (active high, synchronous) is high, `wram_ce`, `wram_we` and `map_wr_stb` are all 0, whatever the inputs do.
- R2: `wram_ce` is 1 only while the synchronised M2, the delayed M2, ROM select (`rom_sel_n`=1, deasserted), A14=1 and A13=1 all hold. After M2 rises in the RAM window, `wram_ce` first reads 1 just after the (DELAY+2)-th clock edge that samples M2 high.
- R3: `wram_ce` returns to 0 just after the second clock edge that samples M2 low. This is the same fast cycle in which the synchronised M2 falls.
- R4: In a $E000-$FFFF access, ROM select may fall up to DELAY fast cycles after M2 rises. Such an access never asserts `wram_ce` or `wram_we`.
- R5: `wram_we` equals `wram_ce` qualified by a write (`cpu_rw`=0, where 1 means read). `wram_we` is never 1 while `wram_ce` is 0.
- R6: A mapper write is `rom_sel_n`=0 with `cpu_rw`=0 while M2 is high. For each such M2-high phase, `map_wr_stb` is 1 for exactly one fast cycle: the first cycle in which the synchronised inputs show all three conditions.
- R7: A mapper write phase that directly follows another mapper write phase gives no strobe. Any M2 phase without a mapper write re-arms the strobe.
- R8: `wram_ce` stays 0 when A14 and A13 are not both 1, even with ROM select deasserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast oversampling clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_m2 | input | 1 | CPU phase clock M2 |
| cpu_a14 | input | 1 | CPU address bit 14 |
| cpu_a13 | input | 1 | CPU address bit 13 |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| rom_sel_n | input | 1 | ROM select, active low, low only when A15=1 and M2=1 |
| wram_ce | output | 1 | Work-RAM chip enable, active high |
| wram_we | output | 1 | Work-RAM write enable, active high |
| map_wr_stb | output | 1 | One-cycle mapper register write strobe |

## Verification
If the delay line held too few stages or failed to clear, a pulse on `wram_ce` and `wram_we` would show at the ports within a few fast cycles of M2 rising in a $E000-$FFFF write. A fault in the write-tracking flags would show up as a missing strobe or a duplicate strobe, visible by the next M2 phase after a read-modify-write pair. A synchroniser fault would shift the first and last enable cycles away from their fixed latencies, and the bench measures both of those against the tick at which M2 changed.

// File: rtl/wram_decode_pkg.sv
package wram_decode_pkg;

    typedef struct packed {
        logic m2;
        logic a14;
        logic a13;
        logic rw;
        logic romsel_n;
    } cpu_bus_t;

    localparam int BUS_W = $bits(cpu_bus_t);

    typedef struct packed {
        logic ce;
        logic we;
    } ram_ctl_t;

    typedef struct packed {
        logic m2_q;
        logic phase_wr;
        logic prev_wr;
    } wr_track_t;

    function automatic logic in_ram_window(input cpu_bus_t b);
        return b.a14 & b.a13 & b.romsel_n;
    endfunction

    function automatic logic is_mapper_write(input cpu_bus_t b);
        return ~b.romsel_n & ~b.rw;
    endfunction

endpackage

// File: rtl/wd_sync.sv
module wd_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst)
                pipe[i] <= '0;
            else if (i == 0)
                pipe[i] <= d;
            else
                pipe[i] <= pipe[(i == 0) ? 0 : i-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/wd_m2_delay.sv
module wd_m2_delay #(
    parameter int DELAY = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic m2_in,
    output logic m2_dly
);
    if (DELAY == 1) begin : g_single
        logic q;
        always_ff @(posedge clk) begin
            if (rst) q <= 1'b0;
            else     q <= m2_in;
        end
        assign m2_dly = q;
    end else begin : g_line
        logic [DELAY-1:0] line;
        always_ff @(posedge clk) begin
            if (rst) line <= '0;
            else     line <= {line[DELAY-2:0], m2_in};
        end
        assign m2_dly = line[DELAY-1];
    end
endmodule

// File: rtl/wd_ram_ctl.sv
module wd_ram_ctl
    import wram_decode_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  cpu_bus_t bus,
    input  logic     m2_dly,
    output ram_ctl_t ctl
);
    always_comb begin
        ctl.ce = ~rst & bus.m2 & m2_dly & in_ram_window(bus);
        ctl.we = ctl.ce & ~bus.rw;
    end

    AST_WE_ONLY_WITH_CE: assert property (@(posedge clk) disable iff (rst)
        ctl.we |-> ctl.ce); // R5
    AST_CE_DROPS_WITH_M2: assert property (@(posedge clk) disable iff (rst)
        $fell(bus.m2) |-> !ctl.ce); // R3
    AST_CE_AFTER_SETTLE: assert property (@(posedge clk) disable iff (rst)
        ctl.ce |-> $past(bus.m2)); // R4
endmodule

// File: rtl/wd_map_write.sv
module wd_map_write
    import wram_decode_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  cpu_bus_t bus,
    output logic     strobe
);
    wr_track_t st;
    logic      mw;

    assign mw     = is_mapper_write(bus);
    assign strobe = ~rst & bus.m2 & mw & ~st.phase_wr & ~st.prev_wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else begin
            st.m2_q     <= bus.m2;
            st.phase_wr <= bus.m2 ? (st.phase_wr | mw) : 1'b0;
            if (st.m2_q && !bus.m2)
                st.prev_wr <= st.phase_wr;
        end
    end

    AST_STB_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        strobe |=> !strobe); // R6
endmodule

// File: rtl/wram_decode.sv
module wram_decode
    import wram_decode_pkg::*;
#(
    parameter int DELAY       = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic cpu_m2,
    input  logic cpu_a14,
    input  logic cpu_a13,
    input  logic cpu_rw,
    input  logic rom_sel_n,
    output logic wram_ce,
    output logic wram_we,
    output logic map_wr_stb
);
    cpu_bus_t raw_bus;
    cpu_bus_t s_bus;
    logic     m2_dly;
    ram_ctl_t ctl;

    assign raw_bus = '{m2: cpu_m2, a14: cpu_a14, a13: cpu_a13,
                       rw: cpu_rw, romsel_n: rom_sel_n};

    wd_sync #(.W(BUS_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_bus),
        .q   (s_bus)
    );

    wd_m2_delay #(.DELAY(DELAY)) u_dly (
        .clk    (clk),
        .rst    (rst),
        .m2_in  (s_bus.m2),
        .m2_dly (m2_dly)
    );

    wd_ram_ctl u_ram (
        .clk    (clk),
        .rst    (rst),
        .bus    (s_bus),
        .m2_dly (m2_dly),
        .ctl    (ctl)
    );

    wd_map_write u_map (
        .clk    (clk),
        .rst    (rst),
        .bus    (s_bus),
        .strobe (map_wr_stb)
    );

    assign wram_ce = ctl.ce;
    assign wram_we = ctl.we;

    AST_WINDOW_ADDR: assert property (@(posedge clk) disable iff (rst)
        wram_ce |-> ($past(cpu_a14, SYNC_STAGES) && $past(cpu_a13, SYNC_STAGES))); // R8
    AST_MAP_IS_WRITE: assert property (@(posedge clk) disable iff (rst)
        map_wr_stb |-> (!$past(cpu_rw, SYNC_STAGES) && !$past(rom_sel_n, SYNC_STAGES))); // R6
endmodule

// File: tb/wram_decode_test.sv
`timescale 1ns/1ps
module wram_decode_test;
    localparam int D = 3;
    localparam int S = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cpu_m2 = 0, cpu_a14 = 0, cpu_a13 = 0, cpu_rw = 1, rom_sel_n = 1;
    logic wram_ce, wram_we, map_wr_stb;

    int checks = 0;
    int fails  = 0;
    int tn     = 0;

    logic [4:0] hist [16];
    logic [4:0] sprev = '0;
    logic mq = 0, ph = 0, pv = 0;

    int en_cnt, we_cnt, stb_cnt, first_en, last_en, t_rise, t_fall;

    always #2 clk = ~clk;

    wram_decode #(.DELAY(D), .SYNC_STAGES(S)) uut (
        .clk(clk), .rst(rst), .cpu_m2(cpu_m2), .cpu_a14(cpu_a14),
        .cpu_a13(cpu_a13), .cpu_rw(cpu_rw), .rom_sel_n(rom_sel_n),
        .wram_ce(wram_ce), .wram_we(wram_we), .map_wr_stb(map_wr_stb)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0d)", req, act, exp, tn);
        end
    endtask

    function automatic logic mapw(input logic [4:0] v);
        return ~v[0] & ~v[1];
    endfunction

    task automatic clear_stats();
        en_cnt = 0; we_cnt = 0; stb_cnt = 0; first_en = -1; last_en = -1;
    endtask

    // bit order: [4]=m2 [3]=a14 [2]=a13 [1]=rw [0]=rom_sel_n
    task automatic tick(input logic [4:0] v);
        logic [4:0] s;
        logic dm, e_ce, e_we, e_stb, npv, nph;
        @(negedge clk);
        {cpu_m2, cpu_a14, cpu_a13, cpu_rw, rom_sel_n} = v;
        @(posedge clk);
        #1;
        tn++;
        hist[tn[3:0]] = rst ? 5'b0 : v;
        if (rst) begin
            mq = 0; ph = 0; pv = 0; sprev = '0;
            chk(!wram_ce && !wram_we && !map_wr_stb, "R1",
                {wram_ce, wram_we, map_wr_stb}, 0);
        end else begin
            s  = hist[(tn - (S - 1)) & 15];
            dm = hist[(tn - (S - 1) - D) & 15][4];
            npv = (mq && !sprev[4]) ? ph : pv;
            nph = sprev[4] ? (ph | mapw(sprev)) : 1'b0;
            mq = sprev[4]; pv = npv; ph = nph;
            e_ce  = s[4] & dm & s[3] & s[2] & s[0];
            e_we  = e_ce & ~s[1];
            e_stb = s[4] & mapw(s) & ~ph & ~pv;
            sprev = s;
            chk(wram_ce == e_ce, "R2", wram_ce, e_ce);
            chk(wram_we == e_we, "R5", wram_we, e_we);
            chk(map_wr_stb == e_stb, "R6/R7", map_wr_stb, e_stb);
        end
        if (wram_ce) begin
            en_cnt++;
            if (first_en < 0) first_en = tn;
            last_en = tn;
        end
        if (wram_we) we_cnt++;
        if (map_wr_stb) stb_cnt++;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick(5'b0_0_0_1_1);
    endtask

    task automatic bus_cycle(input logic a14, input logic a13, input logic rw,
                             input logic rom, input int lag, input int lo, input int hi);
        for (int k = 0; k < lo; k++) tick({1'b0, a14, a13, rw, 1'b1});
        t_rise = tn + 1;
        for (int k = 0; k < hi; k++)
            tick({1'b1, a14, a13, rw, rom ? (k < lag) : 1'b1});
        t_fall = tn + 1;
    endtask

    task automatic random_cycles(input int n);
        for (int i = 0; i < n; i++) begin
            int region = $urandom % 3;
            logic a14, a13, rw;
            rw = $urandom % 2;
            if (region == 1) begin
                a14 = 1; a13 = 1;
            end else begin
                a14 = $urandom % 2; a13 = $urandom % 2;
                if (region == 0 && a14 && a13) a13 = 0;
            end
            bus_cycle(a14, a13, rw, region == 2, $urandom % (D + 1),
                      4 + $urandom % 3, 4 + $urandom % 3);
        end
    endtask

    initial begin
        #(4 * 150000);
        fails++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", tn, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0c3a));
        for (int i = 0; i < 16; i++) hist[i] = '0;
        clear_stats();
        // R1: reset held while a RAM write is driven
        for (int i = 0; i < 10; i++) tick(5'b1_1_1_0_1);
        @(negedge clk) rst = 1'b0;
        idle(4);

        // R2 / R3: RAM read latency
        clear_stats();
        bus_cycle(1, 1, 1, 0, 0, 5, 5);
        idle(4);
        chk(first_en == t_rise + D + S - 1, "R2 first enable", first_en, t_rise + D + S - 1);
        chk(last_en == t_fall + S - 2, "R3 last enable", last_en, t_fall + S - 2);

        // R5: RAM write
        clear_stats();
        bus_cycle(1, 1, 0, 0, 0, 5, 6);
        idle(4);
        chk(we_cnt == en_cnt && we_cnt > 0, "R5 write enables", we_cnt, en_cnt);

        // R4 / R6: mapper write at $E000 with maximum glitch
        clear_stats();
        bus_cycle(1, 1, 0, 1, D, 5, 6);
        idle(4);
        chk(en_cnt == 0, "R4 glitch enable", en_cnt, 0);
        chk(stb_cnt == 1, "R6 strobe", stb_cnt, 1);

        // R7: two further back-to-back mapper writes give no strobe
        clear_stats();
        bus_cycle(1, 1, 0, 1, 1, 5, 5);
        bus_cycle(1, 1, 0, 1, 0, 5, 5);
        idle(3);
        chk(stb_cnt == 0, "R7 consecutive", stb_cnt, 0);
        chk(en_cnt == 0 && we_cnt == 0, "R4 lag0 enable", en_cnt + we_cnt, 0);

        // R7: read cycle re-arms, then RMW read/write/write yields one strobe
        clear_stats();
        bus_cycle(0, 1, 1, 1, 2, 5, 5);
        bus_cycle(0, 1, 0, 1, 2, 5, 5);
        bus_cycle(0, 1, 0, 1, 2, 5, 5);
        idle(3);
        chk(stb_cnt == 1, "R7 rmw", stb_cnt, 1);

        // R8: outside the window
        clear_stats();
        bus_cycle(1, 0, 0, 0, 0, 5, 6);
        bus_cycle(0, 1, 0, 0, 0, 5, 6);
        idle(3);
        chk(en_cnt == 0 && we_cnt == 0, "R8 window miss", en_cnt + we_cnt, 0);

        random_cycles(400);

        // R1: mid-run reset during activity
        @(negedge clk) rst = 1'b1;
        for (int i = 0; i < 8; i++) tick(5'b1_1_1_0_1);
        @(negedge clk) rst = 1'b0;
        idle(3);
        random_cycles(300);
        idle(4);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule